// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog for a peripheral bus. A 7-bit downcounter steps once per counter tick. The tick comes from the peripheral clock divided by a fixed factor, which is 4096 by default. A programmable power-of-two stage then divides it further by 1, 2, 4 or 8. Once software has armed the watchdog, it has to refresh the counter at the right time. A refresh made while the counter is still above a programmed window value is treated as a fault. Letting the counter fall past its halfway value of 0x40 is also a fault. Either fault raises a one-cycle system reset request.

An early-warning flag gives software a last chance to act. The flag is set when the counter counts down onto 0x40, one tick before the reset would follow. Software can enable an interrupt on this flag, but once enabled the interrupt cannot be turned off again.

The block has three word registers on a simple write-strobe bus with a combinational read port:

| Offset | Register | Contents |
|--------|----------|----------|
| 0x00 | control | counter and arm bit |
| 0x04 | configuration | window, time base and interrupt enable |
| 0x08 | status | early-warning flag |

Top module: `window_watchdog`

## Requirements
- R1: After reset, the following hold: offset 0x00 reads 0x7F (counter 0x7F, arm bit clear); offset 0x04 reads 0x7F (window 0x7F, time base 0, enable clear); offset 0x08 reads 0; `wdog_rst_req` and `early_irq` are low.
- R2: The counter decrements by one every FIX_DIV × 2^tb clock edges, where tb is configuration bits 8:7. The first decrement falls FIX_DIV × 2^tb edges after a control write, because a control write restarts the prescaler. The counter wraps from 0x00 to 0x7F.
- R3: A write to offset 0x00 loads the counter from bits 6:0. Bit 7 sets the arm bit, and writing 0 to bit 7 never clears it. A read returns the arm bit in bit 7 and the counter in bits 6:0, with zeros above.
- R4: A write to offset 0x04 loads the window from bits 6:0 and the time base from bits 8:7. Bit 9 sets the interrupt enable, which only a reset clears. A read returns the same layout, with zeros above bit 9.
- R5: When the arm bit is set and a tick takes the counter from 0x40 to 0x3F, `wdog_rst_req` is high for exactly the one cycle that follows that edge. With the arm bit clear, no request is raised.
- R6: A control write made while the arm bit was already set and the counter is above the window raises `wdog_rst_req` for one cycle after the write, and the write still loads the counter. A write made at or below the window, or while the arm bit was clear, raises no request.
- R7: Status bit 0 is set when a tick takes the counter from 0x41 to 0x40, whether or not the interrupt enable is set.
- R8: Writing offset 0x08 with bit 0 = 0 clears the flag, and writing bit 0 = 1 leaves it unchanged. If a set and a clear fall on the same edge, the flag ends up set.
- R9: `early_irq` is high exactly while both the flag and the interrupt enable are set.
- R10: Offsets other than 0x00, 0x04 and 0x08 read as 0, and writes to them change no register.
- R11: If a control write and a tick fall on the same edge, the written value is loaded and no decrement happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdog_rst_req | output | 1 | One-cycle system reset request |
| early_irq | output | 1 | Early-warning interrupt |

## Verification
The assertions take for granted that the bus only ever presents a write as a single-cycle strobe with a stable offset and data. They also assume nothing outside the block alters the time base in the middle of a prescaler period in a way that software would need to observe.

The stimulus keeps every change of the time base directly between two control writes. As a result, the prescaler always restarts around a new time base. The reference model in the bench, which tracks a single phase count, then matches the two-stage hardware divider edge for edge.

// File: rtl/wwd_pkg.sv
// Shared constants and types for the windowed watchdog.
// Assumes byte offsets on a 4-bit address and 32-bit data words.
package wwd_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CFG,
        SEL_STAT
    } reg_sel_e;
endpackage

// File: rtl/wwd_prescaler.sv
// Two-stage tick generator: a fixed divide-by-FIX_DIV stage followed by
// a divide-by-2^tb stage. Emits a one-cycle tick at the end of each period.
// Assumes tb is held steady between restarts; a restart zeroes both stages.
module wwd_prescaler #(
    parameter int FIX_DIV = 4096,
    parameter int TB_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [TB_W-1:0] tb,
    output logic            tick
);
    localparam int SUB_W = (1 << TB_W) - 1;

    logic             fix_end;
    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] sub_lim;

    assign sub_lim = SUB_W'((1 << tb) - 1);
    assign tick    = fix_end && (sub_q >= sub_lim);

    generate
        if (FIX_DIV > 1) begin : g_div
            localparam int FW = $clog2(FIX_DIV);
            logic [FW-1:0] fix_q;

            assign fix_end = (fix_q == FW'(FIX_DIV - 1));

            // Fixed divider: counts edges within one base period.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    fix_q <= '0;
                end else if (fix_end) begin
                    fix_q <= '0;
                end else begin
                    fix_q <= fix_q + 1'b1;
                end
            end

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
            AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick); // R2
        end else begin : g_nodiv
            assign fix_end = 1'b1;
        end
    endgenerate

    // Power-of-two stage: counts base periods up to the selected limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sub_q <= '0;
        end else if (fix_end) begin
            if (sub_q >= sub_lim) begin
                sub_q <= '0;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wwd_downcount.sv
// Downcounter with arm bit and fault detection. A load takes priority over
// a tick. Raises a registered one-cycle reset request on an early refresh
// or when the armed count drops below half scale.
// Assumes load is a single-cycle strobe.
module wwd_downcount #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             arm_set,
    input  logic [CNT_W-1:0] win,
    output logic [CNT_W-1:0] cnt,
    output logic             armed,
    output logic             rst_req,
    output logic             early_hit
);
    localparam logic [CNT_W-1:0] THR  = CNT_W'(1 << (CNT_W - 1));
    localparam logic [CNT_W-1:0] PREW = CNT_W'((1 << (CNT_W - 1)) + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             arm_q;
    logic             req_q;
    logic             step;
    logic             early_fault;
    logic             fall_fault;

    assign step        = tick && !load;
    assign early_fault = load && arm_q && (cnt_q > win);
    assign fall_fault  = step && arm_q && (cnt_q == THR);
    assign early_hit   = step && (cnt_q == PREW);

    // Counter: load wins, otherwise step down on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Arm bit: set by software, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (load && arm_set) begin
            arm_q <= 1'b1;
        end
    end

    // Reset request: one cycle after either fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= early_fault || fall_fault;
        end
    end

    assign cnt     = cnt_q;
    assign armed   = arm_q;
    assign rst_req = req_q;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val)); // R11
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q)); // R2
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |=> arm_q); // R3
    AST_FALL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && tick && !load && cnt_q == THR) |=> rst_req); // R5
    AST_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (load && arm_q && cnt_q > win) |=> rst_req); // R6
    AST_NO_REQ_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_q |=> !rst_req); // R5
endmodule

// File: rtl/window_watchdog.sv
// Windowed watchdog top: register decode, configuration, early-warning
// flag and read mux around the prescaler and the downcounter.
// Assumes single-cycle write strobes and byte offsets on bus_addr.
module window_watchdog
    import wwd_pkg::*;
#(
    parameter int FIX_DIV = 4096,
    parameter int CNT_W   = 7,
    parameter int TB_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdog_rst_req,
    output logic              early_irq
);
    localparam int ARM_BIT = CNT_W;
    localparam int TB_LO   = CNT_W;
    localparam int EN_BIT  = CNT_W + TB_W;

    reg_sel_e         sel;
    logic             wr_ctrl;
    logic             wr_cfg;
    logic             wr_stat;
    logic [CNT_W-1:0] win_q;
    logic [TB_W-1:0]  tb_q;
    logic             en_q;
    logic             flag_q;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             early_hit;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:EN_BIT+1];

    // Address decode to a register select.
    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: sel = SEL_CTRL;
            OFS_CFG:  sel = SEL_CFG;
            OFS_STAT: sel = SEL_STAT;
            default:  sel = SEL_NONE;
        endcase
    end

    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
    assign wr_cfg  = bus_wr && (sel == SEL_CFG);
    assign wr_stat = bus_wr && (sel == SEL_STAT);

    // Configuration: window and time base, set-only interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '1;
            tb_q  <= '0;
            en_q  <= 1'b0;
        end else if (wr_cfg) begin
            win_q <= bus_wdata[CNT_W-1:0];
            tb_q  <= bus_wdata[TB_LO +: TB_W];
            if (bus_wdata[EN_BIT]) begin
                en_q <= 1'b1;
            end
        end
    end

    // Early-warning flag: hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (early_hit) begin
            flag_q <= 1'b1;
        end else if (wr_stat && !bus_wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    wwd_prescaler #(
        .FIX_DIV (FIX_DIV),
        .TB_W    (TB_W)
    ) i_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_ctrl),
        .tb      (tb_q),
        .tick    (tick)
    );

    wwd_downcount #(
        .CNT_W     (CNT_W)
    ) i_downcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (wr_ctrl),
        .load_val  (bus_wdata[CNT_W-1:0]),
        .arm_set   (bus_wdata[ARM_BIT]),
        .win       (win_q),
        .cnt       (cnt),
        .armed     (armed),
        .rst_req   (wdog_rst_req),
        .early_hit (early_hit)
    );

    // Read mux: selected register, zero-extended.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                bus_rdata[CNT_W-1:0] = cnt;
                bus_rdata[ARM_BIT]   = armed;
            end
            SEL_CFG: begin
                bus_rdata[CNT_W-1:0]     = win_q;
                bus_rdata[TB_LO +: TB_W] = tb_q;
                bus_rdata[EN_BIT]        = en_q;
            end
            SEL_STAT: bus_rdata[0] = flag_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign early_irq = flag_q && en_q;

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q); // R4
    AST_FLAG_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(wr_stat && !bus_wdata[0])); // R8
    AST_FLAG_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick) && cnt == CNT_W'(1 << (CNT_W - 1))); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> bus_rdata == '0); // R10
endmodule

// File: tb/test_window_watchdog.sv
module test_window_watchdog;
    localparam int BFIX = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_rst_req;
    logic        early_irq;

    int n_chk = 0;
    int n_err = 0;
    int n_req = 0;
    int cycles = 0;
    bit done = 0;
    bit model_live = 0;

    // Behavioural reference state.
    int m_cnt, m_arm, m_win, m_tb, m_en, m_flag, m_ph, m_req;
    int per, nreq, setf;
    bit tk;

    always #10 clk = ~clk;

    window_watchdog #(.FIX_DIV(BFIX)) i_window_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_rst_req(wdog_rst_req), .early_irq(early_irq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return (m_arm << 7) | m_cnt;
            4'h4: return (m_en << 9) | (m_tb << 7) | m_win;
            4'h8: return m_flag;
            default: return 0;
        endcase
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 127; m_arm = 0; m_win = 127; m_tb = 0; m_en = 0;
            m_flag = 0; m_ph = 0; m_req = 0; model_live = 1;
        end else begin
            nreq = 0; setf = 0;
            per = BFIX << m_tb;
            tk = (m_ph == per - 1);
            if (bus_wr && bus_addr == 4'h0) begin
                if (m_arm == 1 && m_cnt > m_win) nreq = 1;
                m_cnt = int'(bus_wdata[6:0]);
                if (bus_wdata[7]) m_arm = 1;
                m_ph = 0;
            end else if (tk) begin
                if (m_arm == 1 && m_cnt == 64) nreq = 1;
                if (m_cnt == 65) setf = 1;
                m_cnt = (m_cnt + 127) % 128;
                m_ph = 0;
            end else begin
                m_ph++;
            end
            if (setf == 1) m_flag = 1;
            else if (bus_wr && bus_addr == 4'h8 && !bus_wdata[0]) m_flag = 0;
            if (bus_wr && bus_addr == 4'h4) begin
                m_win = int'(bus_wdata[6:0]);
                m_tb = int'(bus_wdata[8:7]);
                if (bus_wdata[9]) m_en = 1;
            end
            m_req = nreq;
        end
    end

    // Every-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        #2;
        if (model_live && !done) begin
            chk(wdog_rst_req == m_req[0], "R5/R6 model rst_req", wdog_rst_req, m_req);
            chk(early_irq == (m_flag == 1 && m_en == 1), "R9 model irq", early_irq, m_flag & m_en);
            chk(bus_rdata == exp_rd(bus_addr), "R3/R4 model rdata", bus_rdata, exp_rd(bus_addr));
            if (wdog_rst_req) n_req++;
        end
    end

    // Watchdog for a hung run.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    initial begin
        int v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, v); chk(v == 32'h7F, "R1 ctrl reset", v, 32'h7F);
        chk(wdog_rst_req == 1'b0, "R1 rst_req reset", wdog_rst_req, 0);
        chk(early_irq == 1'b0, "R1 irq reset", early_irq, 0);
        rd(4'h4, v); chk(v == 32'h7F, "R1 cfg reset", v, 32'h7F);
        rd(4'h8, v); chk(v == 0, "R1 stat reset", v, 0);

        // R7 flag while unarmed, no request (R5)
        repeat (300) @(negedge clk);
        rd(4'h8, v); chk(v == 1, "R7 flag set unarmed", v, 1);
        chk(early_irq == 1'b0, "R9 irq gated by enable", early_irq, 0);
        chk(n_req == 0, "R5 no request unarmed", n_req, 0);

        // R8 write 1 keeps, write 0 clears
        wr(4'h8, 32'h1); rd(4'h8, v); chk(v == 1, "R8 write one ignored", v, 1);
        wr(4'h8, 32'h0); rd(4'h8, v); chk(v == 0, "R8 write zero clears", v, 0);

        // R4 configuration, then arm (R3)
        wr(4'h0, 32'h7F);
        wr(4'h4, 32'h2D0);
        wr(4'h0, 32'hFF);
        rd(4'h4, v); chk(v == 32'h2D0, "R4 cfg readback", v, 32'h2D0);
        rd(4'h0, v); chk(v == 32'hFF, "R3 ctrl armed readback", v, 32'hFF);
        chk(n_req == 0, "R6 no request when arming", n_req, 0);

        // R6 early refresh faults
        wr(4'h0, 32'hFF);
        repeat (2) @(negedge clk);
        chk(n_req == 1, "R6 early refresh request", n_req, 1);

        // R4 enable cannot be cleared
        wr(4'h4, 32'h0D0); rd(4'h4, v); chk(v == 32'h2D0, "R4 enable sticky", v, 32'h2D0);

        // R6 refresh inside window, R3 arm sticky
        n = 0;
        do begin rd(4'h0, v); n++; end while ((v & 32'h7F) >= 32'h50 && n < 2000);
        wr(4'h0, 32'h7F);
        rd(4'h0, v); chk(v == 32'hFF, "R3 arm bit sticky", v, 32'hFF);
        repeat (2) @(negedge clk);
        chk(n_req == 1, "R6 in-window refresh no request", n_req, 1);

        // R7/R9 reach threshold, R5 fall below it
        n = 0;
        do begin rd(4'h0, v); n++; end while ((v & 32'h7F) != 32'h40 && n < 2000);
        rd(4'h8, v); chk(v == 1, "R7 flag at threshold", v, 1);
        chk(early_irq == 1'b1, "R9 irq raised", early_irq, 1);
        n = 0;
        do begin rd(4'h0, v); n++; end while ((v & 32'h7F) != 32'h3F && n < 2000);
        repeat (2) @(negedge clk);
        chk(n_req == 2, "R5 single-cycle request below threshold", n_req, 2);
        wr(4'h8, 32'h0);
        #3 chk(early_irq == 1'b0, "R9 irq drops with flag", early_irq, 0);

        // R2 period with tb=3
        wr(4'h0, 32'h7F);
        wr(4'h4, 32'h3FF);
        wr(4'h0, 32'h7F);
        bus_addr = 4'h0;
        #1;
        n = 0;
        while (bus_rdata[6:0] != 7'h7E && n < 200) begin
            @(negedge clk); #1; n++;
        end
        chk(n == BFIX * 8, "R2 tick period tb=3", n, BFIX * 8);

        // R11 write on a tick edge, R2 restart
        repeat (30) @(negedge clk);
        wr(4'h0, 32'h70);
        #1 chk(bus_rdata == 32'hF0, "R11 write beats tick", bus_rdata, 32'hF0);
        repeat (31) @(negedge clk);
        #1 chk(bus_rdata == 32'hF0, "R2 prescaler restarted", bus_rdata, 32'hF0);
        @(negedge clk);
        #1 chk(bus_rdata == 32'hEF, "R2 first decrement", bus_rdata, 32'hEF);

        // R10 unmapped offset
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, v); chk(v == 0, "R10 unmapped reads zero", v, 0);
        rd(4'h4, v); chk(v == 32'h3FF, "R10 cfg untouched", v, 32'h3FF);
        rd(4'h8, v); chk(v == 0, "R10 stat untouched", v, 0);
        chk(n_req == 2, "R6 no stray request", n_req, 2);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(4'h0, v); chk(v == 32'h7F, "R1 ctrl after reset", v, 32'h7F);
        rd(4'h4, v); chk(v == 32'h7F, "R1 cfg after reset", v, 32'h7F);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule